// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits on the CPU side of an interconnect and decides where each transaction address goes. It holds eight programmable windows. Each window has a control word, a base word and two remap words. Software loads them through a write-only register port. Every lookup address is compared against all enabled windows at once. One clock later the block reports four things: whether a window hit, which window won, that window's target ID and attribute byte, and the address to send downstream.

A window covers a power-of-two number of 64 KiB pages. Its size field is a mask of contiguous ones filled from bit 0 upward, so 0x00FF selects 256 pages (16 MiB) and an all-zero field selects a single 64 KiB page. Only the windows named in a parameter (windows 0 and 1 by default) can translate addresses. Their remap-low word supplies the upper output bits that lie outside the size mask. To get an identity translation on such a window, software sets remap-low equal to the base. On every other window the output address is the input address. The remap-high word is held in the register file but plays no part in the 32-bit lookup.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every window is disabled, no result is flagged valid, and a lookup reports a miss.
- R2: A window hits when its enable bit is set and the page bits of the address match the page bits of its base. Page bits are addr[31:16] with the size-mask bits removed. Address bits [15:0] and base bits [15:0] take no part in the match.
- R3: A size field with N contiguous low ones spans 2^N × 64 KiB. For example, 0x00FF spans 16 MiB and 0x0000 spans exactly one 64 KiB page. The first byte past the span misses.
- R4: A window whose enable bit (control bit 0) is clear never hits, whatever its base and size hold.
- R5: When several enabled windows hit, the result reports the lowest-numbered one.
- R6: On a remap-capable window the output address is ({remap_lo[31:16] & ~size, 16'h0}) | (addr & {size, 16'hFFFF}). Writing remap-high has no effect on it.
- R7: On windows that cannot remap, the output address equals the lookup address, and writes to their remap registers change nothing.
- R8: A miss sets the miss flag, clears the hit flag, and drives the window index, target, attribute and address outputs to zero.
- R9: Each lookup strobe produces exactly one result, one clock later and in order. Cycles without a strobe produce no result.
- R10: The control word places the size in bits [31:16], the attribute in [15:8], the target ID in [7:4] and the enable in bit 0. The register select codes are 0 for control, 1 for base, 2 for remap-low and 3 for remap-high.
- R11: A register write takes effect for a lookup presented in the clock cycle right after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window index of the write |
| wr_sel | input | 2 | Register select: 0 control, 1 base, 2 remap-low, 3 remap-high |
| wr_data | input | 32 | Write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Lookup address |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | A window matched |
| res_miss | output | 1 | No window matched |
| res_win | output | 3 | Winning window index |
| res_target | output | 4 | Target ID of the winning window |
| res_attr | output | 8 | Attribute byte of the winning window |
| res_addr | output | 32 | Translated output address |

## Verification
The assertions assume that software programs only contiguous-ones size masks. They also assume that no write and lookup to the same window are issued in the same cycle; in that case the lookup would still see the old configuration. The stimulus follows both rules. It configures each window fully before looking up addresses in it, and it separates every write from the lookups that depend on it by at least one clock. Lookups are sent both singly and back to back, so the scoreboard's in-order pairing of strobes and results is exercised under load.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned AW     = 32;
  localparam int unsigned GRAN_W = 16;
  localparam int unsigned PAGE_W = AW - GRAN_W;
  localparam int unsigned TGT_W  = 4;
  localparam int unsigned ATTR_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'd0,
    SEL_BASE     = 2'd1,
    SEL_REMAP_LO = 2'd2,
    SEL_REMAP_HI = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PAGE_W-1:0] size;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  target;
    logic              en;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] remap;
  } win_cfg_t;

  // page-granular match: bits inside the size mask are don't-care
  function automatic logic win_hit(win_cfg_t c, logic [AW-1:0] a);
    logic [PAGE_W-1:0] keep;
    keep = ~c.size;
    return c.en && ((a[AW-1:GRAN_W] & keep) == (c.base & keep));
  endfunction

  function automatic logic [AW-1:0] win_xlate(win_cfg_t c, logic [AW-1:0] a,
                                              logic can_remap);
    logic [AW-1:0] pass;
    pass = {c.size, {GRAN_W{1'b1}}};
    if (!can_remap) return a;
    return ({c.remap & ~c.size, {GRAN_W{1'b0}}}) | (a & pass);
  endfunction
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN    = 8,
  parameter logic [NUM_WIN-1:0] REMAP_MASK = 8'b0000_0011,
  localparam int unsigned IDX_W     = $clog2(NUM_WIN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_win,
  input  logic [1:0]                wr_sel,
  input  logic [AW-1:0]             wr_data,
  output win_cfg_t [NUM_WIN-1:0]    cfg
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[3:1];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic sel_me;
    assign sel_me = wr_en && (wr_win == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[i].size   <= '0;
        cfg[i].attr   <= '0;
        cfg[i].target <= '0;
        cfg[i].en     <= 1'b0;
        cfg[i].base   <= '0;
      end else if (sel_me) begin
        if (reg_sel_e'(wr_sel) == SEL_CTRL) begin
          cfg[i].size   <= wr_data[31:16];
          cfg[i].attr   <= wr_data[15:8];
          cfg[i].target <= wr_data[7:4];
          cfg[i].en     <= wr_data[0];
        end else if (reg_sel_e'(wr_sel) == SEL_BASE) begin
          cfg[i].base   <= wr_data[AW-1:GRAN_W];
        end
      end
    end

    if (REMAP_MASK[i]) begin : g_remap
      logic [AW-1:0] remap_hi_q;
      logic          unused_remap_hi;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg[i].remap <= '0;
          remap_hi_q   <= '0;
        end else if (sel_me) begin
          if (reg_sel_e'(wr_sel) == SEL_REMAP_LO) cfg[i].remap <= wr_data[AW-1:GRAN_W];
          if (reg_sel_e'(wr_sel) == SEL_REMAP_HI) remap_hi_q   <= wr_data;
        end
      end
      assign unused_remap_hi = ^remap_hi_q;
    end else begin : g_fixed
      assign cfg[i].remap = '0;
    end
  end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
#(
  parameter bit CAN_REMAP = 1'b0
) (
  input  win_cfg_t      cfg,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] xaddr
);
  logic unused_remap;
  assign hit   = win_hit(cfg, addr);
  assign xaddr = win_xlate(cfg, addr, CAN_REMAP);
  assign unused_remap = CAN_REMAP ? 1'b0 : ^cfg.remap;
endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] req,
  output logic [NUM_WIN-1:0] grant,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN    = 8,
  parameter logic [NUM_WIN-1:0] REMAP_MASK = 8'b0000_0011,
  localparam int unsigned IDX_W     = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_win,
  input  logic [1:0]        wr_sel,
  input  logic [AW-1:0]     wr_data,
  input  logic              lk_valid,
  input  logic [AW-1:0]     lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [IDX_W-1:0]  res_win,
  output logic [TGT_W-1:0]  res_target,
  output logic [ATTR_W-1:0] res_attr,
  output logic [AW-1:0]     res_addr
);
  win_cfg_t [NUM_WIN-1:0] cfg;
  logic [NUM_WIN-1:0]     win_en;
  logic [NUM_WIN-1:0]     raw_hit;
  logic [NUM_WIN-1:0]     grant;
  logic [AW-1:0]          xaddr [NUM_WIN];
  logic [IDX_W-1:0]       pick_idx;
  logic                   pick_any;
  logic [TGT_W-1:0]       pick_tgt;
  logic [ATTR_W-1:0]      pick_attr;
  logic [AW-1:0]          pick_addr;

  awd_regfile #(.NUM_WIN(NUM_WIN), .REMAP_MASK(REMAP_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
    .wr_sel(wr_sel), .wr_data(wr_data), .cfg(cfg)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign win_en[i] = cfg[i].en;
    awd_win_match #(.CAN_REMAP(REMAP_MASK[i])) u_match (
      .cfg(cfg[i]), .addr(lk_addr), .hit(raw_hit[i]), .xaddr(xaddr[i])
    );
  end

  awd_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .req(raw_hit), .grant(grant), .idx(pick_idx), .any(pick_any)
  );

  // AND-OR mux on the one-hot grant
  always_comb begin
    pick_tgt  = '0;
    pick_attr = '0;
    pick_addr = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      pick_tgt  |= cfg[i].target & {TGT_W{grant[i]}};
      pick_attr |= cfg[i].attr   & {ATTR_W{grant[i]}};
      pick_addr |= xaddr[i]      & {AW{grant[i]}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_miss   <= 1'b0;
      res_win    <= '0;
      res_target <= '0;
      res_attr   <= '0;
      res_addr   <= '0;
    end else begin
      res_valid  <= lk_valid;
      res_hit    <= lk_valid && pick_any;
      res_miss   <= lk_valid && !pick_any;
      res_win    <= lk_valid ? pick_idx  : '0;
      res_target <= lk_valid ? pick_tgt  : '0;
      res_attr   <= lk_valid ? pick_attr : '0;
      res_addr   <= lk_valid ? pick_addr : '0;
    end
  end
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int unsigned NUM_WIN    = 8,
  parameter logic [NUM_WIN-1:0] REMAP_MASK = 8'b0000_0011,
  localparam int unsigned IDX_W     = $clog2(NUM_WIN)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [31:0]        lk_addr,
  input logic               res_valid,
  input logic               res_hit,
  input logic               res_miss,
  input logic [IDX_W-1:0]   res_win,
  input logic [3:0]         res_target,
  input logic [7:0]         res_attr,
  input logic [31:0]        res_addr,
  input logic [NUM_WIN-1:0] win_en,
  input logic [NUM_WIN-1:0] raw_hit,
  input logic [NUM_WIN-1:0] grant
);
  a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  a_r8_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss));
  a_r8_miss_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_win == '0 && res_target == '0 && res_attr == '0 && res_addr == '0));
  a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~raw_hit) == '0));
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_addr[15:0] == $past(lk_addr[15:0]));
  a_r7_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && !REMAP_MASK[res_win]) |-> res_addr == $past(lk_addr));

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_en
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en[i] |-> !raw_hit[i]);
  end
endmodule

bind addr_win_decoder awd_checker #(.NUM_WIN(NUM_WIN), .REMAP_MASK(REMAP_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
  .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
  .res_addr(res_addr), .win_en(win_en), .raw_hit(raw_hit), .grant(grant)
);

// File: tb/sim_addr_win_decoder.sv
module sim_addr_win_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_win = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit, res_miss;
  logic [2:0]  res_win;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [31:0] res_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_win_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
    .wr_data(wr_data), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
    .res_addr(res_addr)
  );

  typedef struct {
    logic        hit;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] addr;
    string       req;
  } exp_t;

  exp_t scb[$];

  // bench-side model of the programmed windows
  logic [15:0] m_size [8];
  logic [7:0]  m_attr [8];
  logic [3:0]  m_tgt  [8];
  logic        m_en   [8];
  logic [31:0] m_base [8];
  logic [31:0] m_remap[8];

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_size[i] = '0; m_attr[i] = '0; m_tgt[i] = '0; m_en[i] = 1'b0;
      m_base[i] = '0; m_remap[i] = '0;
    end
  end

  function automatic exp_t predict(logic [31:0] a, string req);
    exp_t e;
    e.hit = 1'b0; e.win = '0; e.tgt = '0; e.attr = '0; e.addr = '0; e.req = req;
    for (int i = 7; i >= 0; i--) begin
      logic [31:0] span;
      span = {m_size[i], 16'hFFFF};
      if (m_en[i] && (((a ^ m_base[i]) & ~span) == 32'h0)) begin
        e.hit = 1'b1; e.win = 3'(i); e.tgt = m_tgt[i]; e.attr = m_attr[i];
        e.addr = (i < 2) ? ((m_remap[i] & ~span) | (a & span)) : a;
      end
    end
    return e;
  endfunction

  function automatic void check(bit ok, string req, string what,
                                logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endfunction

  task automatic write_reg(int w, int sel, logic [31:0] d);
    wr_en = 1'b1; wr_win = 3'(w); wr_sel = 2'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      0: begin m_size[w] = d[31:16]; m_attr[w] = d[15:8]; m_tgt[w] = d[7:4]; m_en[w] = d[0]; end
      1: m_base[w] = d;
      2: if (w < 2) m_remap[w] = d;
      default: ;
    endcase
  endtask

  task automatic lookup(logic [31:0] a, string req);
    scb.push_back(predict(a, req));
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic setup(int w, logic [31:0] base, logic [15:0] size,
                       logic [7:0] attr, logic [3:0] tgt);
    write_reg(w, 0, 32'h0);
    write_reg(w, 1, base);
    write_reg(w, 0, {size, attr, tgt, 3'b000, 1'b1});
  endtask

  // monitor: pairs each result with the oldest expected entry
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (scb.size() == 0) begin
        check(1'b0, "R9", "result without lookup", 32'(res_valid), 32'h0);
      end else begin
        exp_t e;
        e = scb.pop_front();
        check(res_hit == e.hit && res_miss == !e.hit, e.req, "hit flag",
              32'(res_hit), 32'(e.hit));
        check(res_win == e.win && res_target == e.tgt && res_attr == e.attr, e.req,
              "win/target/attr", {20'h0, res_win, res_target, res_attr},
              {20'h0, e.win, e.tgt, e.attr});
        check(res_addr == e.addr, e.req, "address", res_addr, e.addr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(!res_valid && !res_hit && !res_miss && res_addr == 0, "R1", "reset outputs",
          {res_valid, res_hit, res_miss, res_addr[28:0]}, 32'h0);
    lookup(32'h1234_5678, "R1");
    lookup(32'h0000_0000, "R8");

    // R10/R2: window 2, 16 MiB at 0x2000_0000
    setup(2, 32'h2000_0000, 16'h00FF, 8'h1D, 4'h5);
    lookup(32'h20AB_CDEF, "R2");
    lookup(32'h20FF_FFFF, "R3");
    lookup(32'h2100_0000, "R3");
    lookup(32'h1FFF_FFFF, "R8");

    // R3: one-page window
    setup(4, 32'h3000_0000, 16'h0000, 8'hA4, 4'h9);
    lookup(32'h3000_FFFF, "R3");
    lookup(32'h3001_0000, "R3");

    // R2: base low bits ignored, 1 MiB window
    setup(5, 32'h4000_ABCD, 16'h000F, 8'h77, 4'hC);
    lookup(32'h400F_0000, "R2");
    lookup(32'h4010_0000, "R2");

    // R4: disabled window with size/base left in place
    write_reg(4, 0, 32'h0000_A490);
    lookup(32'h3000_0010, "R4");

    // R5: overlap of windows 1 and 3
    setup(3, 32'h5000_0000, 16'h00FF, 8'h33, 4'h3);
    setup(1, 32'h5000_0000, 16'h000F, 8'h11, 4'h1);
    write_reg(1, 2, 32'h5000_0000);
    lookup(32'h5000_1000, "R5");
    lookup(32'h5080_0000, "R5");

    // R6: remap on windows 0 and 1
    setup(0, 32'h6000_0000, 16'h00FF, 8'h0E, 4'h2);
    write_reg(0, 2, 32'h9A00_0000);
    lookup(32'h6012_3456, "R6");
    write_reg(0, 3, 32'hFFFF_FFFF);
    lookup(32'h60FE_DCBA, "R6");
    write_reg(1, 2, 32'hC000_0000);
    lookup(32'h5000_1000, "R6");
    write_reg(0, 2, 32'h6000_0000);
    lookup(32'h6055_0001, "R6");

    // R7: remap writes on a fixed window have no effect
    write_reg(3, 2, 32'hE000_0000);
    write_reg(3, 3, 32'h1234_5678);
    lookup(32'h5080_0000, "R7");
    lookup(32'h5000_0000, "R7");

    // R11: write immediately followed by lookup
    setup(6, 32'h7000_0000, 16'h0003, 8'h66, 4'h6);
    lookup(32'h7003_0000, "R11");
    write_reg(6, 0, 32'h0);
    lookup(32'h7003_0000, "R11");

    // R9: burst of back-to-back lookups, then idle cycles
    for (int k = 0; k < 8; k++) lookup(32'h2000_0000 + 32'(k) * 32'h0040_0000, "R9");
    repeat (4) @(negedge clk);
    check(scb.size() == 0, "R9", "pending results", 32'(scb.size()), 32'h0);
    check(!res_valid, "R9", "idle valid", 32'(res_valid), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule